// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a two-wire serial memory of 32,768 bytes. It runs on a fast system clock and samples the raw clock and data lines through two-flop synchronizers. It recognizes start and stop conditions and checks the device address byte against a fixed prefix and two strap inputs. After that it either takes in a two-byte word address and write data, or serves read data. It answers on the data line through an open-drain enable: when `sda_oe` is high, the pad pulls the line low.

Write bytes do not go into a local array. Each accepted byte is handed to a separate page-write engine, together with its computed address. The block pulses a commit strobe at the stop that closes a write. Read bytes come from a synchronous byte-wide memory port with one cycle of latency. An internal word-address counter keeps its value between transactions, which supports current-address, random and sequential reads. While the page-write engine reports that its write cycle is busy, the block acknowledges nothing, so the host can poll for completion.

Top module: `twi_mem_target`

## Requirements
- R1: A data falling edge while the clock is high is a start and a data rising edge while the clock is high is a stop. Either one aborts a byte in progress. A stop leaves the engine idle with the data line released, and a start makes it wait for a device address byte.
- R2: The device address byte is, from bit 7 down, 1,0,1,0, then 0, then bits equal to `strap[1]` and `strap[0]`, then the direction bit (1 = read). When it matches and the write cycle is not busy, the block pulls the data line low during the ninth clock.
- R3: When the device address byte does not match, the block gives no acknowledge and ignores all traffic up to the next start. It then drives nothing and hands over no write bytes.
- R4: A write sends the high address byte, then the low address byte, after the device address. Bit 7 of the high byte is ignored. Every address byte and data byte is acknowledged, and every data byte appears as a one-cycle `wb_valid` pulse with its address and value.
- R5: Within a write, each following data byte goes to the next address. Only the low 6 address bits count, so the address wraps from offset 63 to offset 0 of the same 64-byte page.
- R6: `wr_commit` pulses for one cycle at a stop that closes a transaction in which at least one data byte was accepted. An address-only write does not pulse it.
- R7: The word-address counter holds the address after the last byte accessed and keeps it between transactions. After a write, that address is the next address within the same page. A current-address read returns the byte at the counter. Each byte sent costs exactly one `mem_rd_en` pulse, and the first pulse is issued when the read address byte is acknowledged.
- R8: A random read, made of a write that carries only the address, then a repeated start and a read address byte, returns the byte at the loaded address.
- R9: During a read, a host acknowledge makes the block send the byte at the next address, wrapping from 0x7FFF to 0x0000. A host non-acknowledge ends the read with the line released.
- R10: While `wr_busy` is high, the block acknowledges no byte, including its own device address, and hands over no write bytes.
- R11: The block changes `sda_oe` only while the clock line is low. Data bits are taken at clock rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line as seen on the pad |
| strap | input | 2 | Hardwired address strap bits |
| wr_busy | input | 1 | Page-write engine is in its internal write cycle |
| sda_oe | output | 1 | Pull data line low when high |
| mem_rd_en | output | 1 | Read strobe to the memory array |
| mem_rd_addr | output | 15 | Read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| wb_valid | output | 1 | One-cycle pulse: a write byte is ready |
| wb_addr | output | 15 | Address of the write byte |
| wb_data | output | 8 | Value of the write byte |
| wr_commit | output | 1 | One-cycle pulse at the stop that ends a write |

## Verification
The assertions assume a well-behaved host. The host changes data only while the clock is low, except to form a start or stop. Every clock phase lasts longer than the synchronizer delay of three system cycles. `wr_busy` changes only between transactions. The bench drives the lines through tasks whose quarter-bit phase is five system clocks. It raises and lowers `wr_busy` only while the bus is idle. Within one write it never repeats a start without a stop in between. This keeps the page-step check and the rule that `sda_oe` moves only while the clock is low meaningful. The random part picks addresses, lengths, data and read styles from `$urandom`. The directed part covers page wrap, array wrap, address mismatch, busy polling and aborted bytes.

// File: rtl/twi_mem_target.sv
module twi_mem_target #(
  parameter int AW = 15,
  parameter int PW = 6,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    strap,
  input  logic          wr_busy,
  output logic          sda_oe,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [7:0]    wb_data,
  output logic          wr_commit
);
  localparam int HW = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD} st_t;

  logic [2:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_s, sda_q;
  logic rise, fall, start_c, stop_c;

  st_t st;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx;
  logic [AW-1:0] ptr;
  logic [HW-1:0] ahi;
  logic          host_ack, got_data, fetch_d;
  logic          dev_match, ack_ok;
  logic [AW-1:0] ptr_page_inc;

  assign scl_s   = scl_p[1];
  assign scl_q   = scl_p[2];
  assign sda_s   = sda_p[1];
  assign sda_q   = sda_p[2];
  assign rise    = ~scl_q & scl_s;
  assign fall    = scl_q & ~scl_s;
  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  assign dev_match    = (sh[7:4] == DEV_ID) && !sh[3] && (sh[2:1] == strap);
  assign ack_ok       = !wr_busy && (st != S_DEV || dev_match);
  assign ptr_page_inc = {ptr[AW-1:PW], PW'(ptr[PW-1:0] + 1'b1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      sh          <= '0;
      tx          <= '0;
      ptr         <= '0;
      ahi         <= '0;
      host_ack    <= 1'b0;
      got_data    <= 1'b0;
      fetch_d     <= 1'b0;
      sda_oe      <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      wb_valid    <= 1'b0;
      wb_addr     <= '0;
      wb_data     <= '0;
      wr_commit   <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      wb_valid  <= 1'b0;
      wr_commit <= 1'b0;
      fetch_d   <= mem_rd_en;
      if (fetch_d) tx <= mem_rd_data;

      if (start_c) begin
        st       <= S_DEV;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else if (stop_c) begin
        st        <= S_IDLE;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        wr_commit <= got_data;
        got_data  <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (cnt < 4'd9) cnt <= cnt + 1'b1;
          if (cnt < 4'd8 && st != S_RD) sh <= {sh[6:0], sda_s};
          if (cnt == 4'd8 && st == S_RD) begin
            host_ack <= ~sda_s;
            if (!sda_s) begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= ptr;
              ptr         <= ptr + 1'b1;
            end
          end
        end else if (fall) begin
          if (cnt == 4'd8 && st != S_RD) begin
            if (!ack_ok) begin
              st     <= S_IDLE;
              sda_oe <= 1'b0;
            end else begin
              sda_oe <= 1'b1;
              case (st)
                S_DEV: if (sh[0]) begin
                  mem_rd_en   <= 1'b1;
                  mem_rd_addr <= ptr;
                  ptr         <= ptr + 1'b1;
                end
                S_AHI: ahi <= sh[HW-1:0];
                S_ALO: ptr <= {ahi, sh};
                S_WR: begin
                  wb_valid <= 1'b1;
                  wb_addr  <= ptr;
                  wb_data  <= sh;
                  ptr      <= ptr_page_inc;
                  got_data <= 1'b1;
                end
                default: ;
              endcase
            end
          end else if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            case (st)
              S_DEV: begin
                st     <= sh[0] ? S_RD : S_AHI;
                sda_oe <= sh[0] ? ~tx[7] : 1'b0;
              end
              S_AHI: begin
                st     <= S_ALO;
                sda_oe <= 1'b0;
              end
              S_RD: begin
                if (host_ack) sda_oe <= ~tx[7];
                else begin
                  st     <= S_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              default: begin
                st     <= S_WR;
                sda_oe <= 1'b0;
              end
            endcase
          end else if (cnt != 4'd0 && st == S_RD) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end
endmodule

module twi_mem_target_chk #(
  parameter int AW = 15,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_c,
  input logic          stop_c,
  input logic          sda_oe,
  input logic          wr_busy,
  input logic          wb_valid,
  input logic [AW-1:0] wb_addr,
  input logic          wr_commit,
  input logic          mem_rd_en
);
  logic          have;
  logic [AW-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have <= 1'b0;
      last <= '0;
    end else if (start_c || stop_c) begin
      have <= 1'b0;
    end else if (wb_valid) begin
      have <= 1'b1;
      last <= wb_addr;
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(start_c) && !$past(stop_c) |-> !scl_s); // R11
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy && $past(wr_busy) |-> !$rose(sda_oe) && !wb_valid); // R10
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid); // R4
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && have |-> wb_addr[AW-1:PW] == last[AW-1:PW] &&
                         wb_addr[PW-1:0] == PW'(last[PW-1:0] + 1'b1)); // R5
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit); // R6
  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R7
endmodule

bind twi_mem_target twi_mem_target_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_c(start_c), .stop_c(stop_c),
  .sda_oe(sda_oe), .wr_busy(wr_busy), .wb_valid(wb_valid), .wb_addr(wb_addr),
  .wr_commit(wr_commit), .mem_rd_en(mem_rd_en)
);

// File: tb/twi_mem_target_test.sv
module twi_mem_target_test;
  localparam int Q = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, hsda = 1'b1, wr_busy = 1'b0;
  logic [1:0] strap = 2'b10;
  logic sda_oe, mem_rd_en, wb_valid, wr_commit;
  logic [14:0] mem_rd_addr, wb_addr;
  logic [7:0] mem_rd_data, wb_data;
  wire sda_bus = hsda & ~sda_oe;

  int tests = 0, fails = 0;
  int wb_n = 0, commit_n = 0, fetch_n = 0, oe_viol = 0, rd_total = 0;
  logic [14:0] wb_a [0:511];
  logic [7:0]  wb_d [0:511];
  logic oe_prev = 1'b0;
  logic [14:0] exp_ptr = '0;

  always #4 clk = ~clk;

  twi_mem_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap(strap),
    .wr_busy(wr_busy), .sda_oe(sda_oe), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_data(wb_data), .wr_commit(wr_commit)
  );

  function automatic logic [7:0] mdata(logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mdata(mem_rd_addr);
    if (mem_rd_en) fetch_n <= fetch_n + 1;
    if (wb_valid) begin
      wb_a[wb_n % 512] <= wb_addr;
      wb_d[wb_n % 512] <= wb_data;
      wb_n <= wb_n + 1;
    end
    if (wr_commit) commit_n <= commit_n + 1;
    if (rst_n && sda_oe != oe_prev && scl) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    hsda = 1'b1; tick(Q); scl = 1'b1; tick(Q); hsda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0; hsda = 1'b0; tick(Q); scl = 1'b1; tick(Q); hsda = 1'b1; tick(2*Q);
  endtask

  task automatic put_bit(input logic b);
    hsda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    hsda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = !a;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!give_ack);
  endtask

  task automatic dev(input logic rw, output logic ack);
    wr_byte({4'b1010, 1'b0, strap, rw}, ack);
  endtask

  task automatic do_write(input logic [14:0] a, input int n, input logic top);
    logic ack;
    logic [7:0] dd [0:127];
    int base, cb;
    bus_start();
    dev(1'b0, ack); chk(ack, "R2", "write device ack", ack, 1);
    wr_byte({top, a[14:8]}, ack); chk(ack, "R4", "high address ack", ack, 1);
    wr_byte(a[7:0], ack); chk(ack, "R4", "low address ack", ack, 1);
    base = wb_n; cb = commit_n;
    for (int i = 0; i < n; i++) begin
      dd[i] = 8'($urandom);
      wr_byte(dd[i], ack); chk(ack, "R4", "data ack", ack, 1);
    end
    bus_stop();
    tick(4);
    chk(wb_n - base == n, "R4", "write byte count", wb_n - base, n);
    for (int i = 0; i < n; i++) begin
      logic [14:0] ea;
      ea = {a[14:6], 6'(a[5:0] + i)};
      chk(wb_a[(base + i) % 512] == ea, "R5", "write address", wb_a[(base + i) % 512], ea);
      chk(wb_d[(base + i) % 512] == dd[i], "R4", "write data", wb_d[(base + i) % 512], dd[i]);
    end
    chk(commit_n == cb + 1, "R6", "commit pulses", commit_n - cb, 1);
    exp_ptr = {a[14:6], 6'(a[5:0] + n)};
  endtask

  task automatic do_read(input bit rnd, input logic [14:0] a, input int n);
    logic ack;
    logic [7:0] v;
    logic [14:0] base;
    int cb;
    cb = commit_n;
    bus_start();
    if (rnd) begin
      dev(1'b0, ack); chk(ack, "R8", "dummy write ack", ack, 1);
      wr_byte({1'b0, a[14:8]}, ack);
      wr_byte(a[7:0], ack); chk(ack, "R8", "address ack", ack, 1);
      bus_start();
      base = a;
    end else base = exp_ptr;
    dev(1'b1, ack); chk(ack, "R2", "read device ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, v);
      chk(v == mdata(base + 15'(i)), rnd ? "R8/R9" : "R7", "read data", v, mdata(base + 15'(i)));
    end
    bus_stop();
    tick(4);
    chk(sda_oe == 1'b0, "R9", "line released after nack", sda_oe, 0);
    if (rnd) chk(commit_n == cb, "R6", "no commit for dummy write", commit_n - cb, 0);
    exp_ptr = base + 15'(n);
    rd_total += n;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    void'($urandom(32'd1234));
    tick(5);
    chk(sda_oe == 0 && wb_valid == 0 && mem_rd_en == 0 && wr_commit == 0, "R1",
        "reset outputs idle", {sda_oe, wb_valid, mem_rd_en, wr_commit}, 0);
    rst_n = 1'b1;
    tick(5);

    do_write(15'h1234, 1, 1'b1);
    do_read(0, 0, 1);
    do_read(0, 0, 1);

    do_write(15'h0AFC, 70, 1'b0);
    chk(exp_ptr == 15'h0AC2, "R7", "bench pointer after page wrap", exp_ptr, 15'h0AC2);
    do_read(0, 0, 1);

    do_read(1, 15'h7FFD, 5);
    do_read(0, 0, 2);

    begin
      int wb0;
      wb0 = wb_n;
      bus_start();
      wr_byte({4'b1010, 1'b0, ~strap, 1'b0}, ack); chk(!ack, "R3", "strap mismatch nack", ack, 0);
      wr_byte(8'h00, ack); chk(!ack, "R3", "ignored byte nack", ack, 0);
      wr_byte(8'h55, ack); chk(!ack, "R3", "ignored byte nack", ack, 0);
      wr_byte(8'hAA, ack); chk(!ack, "R3", "ignored byte nack", ack, 0);
      bus_stop();
      bus_start();
      wr_byte({4'b1010, 1'b1, strap, 1'b1}, ack); chk(!ack, "R3", "bit3 set nack", ack, 0);
      bus_stop();
      bus_start();
      wr_byte({4'b1011, 1'b0, strap, 1'b0}, ack); chk(!ack, "R3", "prefix nack", ack, 0);
      bus_stop();
      tick(4);
      chk(wb_n == wb0, "R3", "no write bytes after mismatch", wb_n - wb0, 0);
    end

    begin
      int wb0;
      wb0 = wb_n;
      wr_busy = 1'b1;
      tick(4);
      bus_start();
      dev(1'b0, ack); chk(!ack, "R10", "busy write address nack", ack, 0);
      wr_byte(8'h01, ack); chk(!ack, "R10", "busy later byte nack", ack, 0);
      bus_stop();
      bus_start();
      dev(1'b1, ack); chk(!ack, "R10", "busy read address nack", ack, 0);
      bus_stop();
      chk(wb_n == wb0, "R10", "no write bytes while busy", wb_n - wb0, 0);
      wr_busy = 1'b0;
      tick(4);
      bus_start();
      dev(1'b0, ack); chk(ack, "R10", "poll ack after busy", ack, 1);
      bus_stop();
    end

    begin
      int wb0, c0;
      wb0 = wb_n; c0 = commit_n;
      bus_start();
      dev(1'b0, ack);
      wr_byte(8'h21, ack);
      wr_byte(8'h40, ack);
      for (int i = 0; i < 4; i++) put_bit(1'b0);
      bus_stop();
      tick(4);
      chk(wb_n == wb0, "R1", "stop aborts byte", wb_n - wb0, 0);
      chk(commit_n == c0, "R1", "no commit after abort", commit_n - c0, 0);
      bus_start();
      dev(1'b0, ack);
      wr_byte(8'h33, ack);
      wr_byte(8'h10, ack);
      for (int i = 0; i < 3; i++) put_bit(1'b1);
      bus_start();
      dev(1'b1, ack); chk(ack, "R1", "start restarts address phase", ack, 1);
      rd_byte(1'b0, v);
      chk(v == mdata(15'h3310), "R1", "read after restart", v, mdata(15'h3310));
      bus_stop();
      chk(wb_n == wb0, "R1", "restart drops partial byte", wb_n - wb0, 0);
      exp_ptr = 15'h3311;
      rd_total += 1;
    end

    for (int it = 0; it < 30; it++) begin
      int kind;
      kind = int'($urandom % 3);
      if (kind == 0) do_write(15'($urandom), 1 + int'($urandom % 3), 1'($urandom));
      else if (kind == 1) do_read(1, 15'($urandom), 1 + int'($urandom % 4));
      else do_read(0, 0, 1 + int'($urandom % 3));
    end

    tick(10);
    chk(fetch_n == rd_total, "R7", "one fetch per byte sent", fetch_n, rd_total);
    chk(oe_viol == 0, "R11", "line changes while clock high", oe_viol, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule